// File: doc/BRIEF.md
# Stream Buffer Prefetch Controller

This block keeps several small prefetch queues, each tracking one run of consecutive cache-line addresses. When the cache misses, the missing line address is checked against the oldest entry of every queue in the same cycle. The block reports one of three outcomes. A hit means the oldest entry matches and its data has already returned, so the entry is removed and the line can go to the cache. A pending hit means the oldest entry matches but its data is still in flight. A miss means nothing matched, so the least recently used queue is taken over for the stream that follows the missing line.

Queues refill themselves through a memory request port. At most one request goes out per cycle, the queues take turns in rotation, and nothing is sent while the memory bus reports busy. Each request carries a tag, and the memory side returns that tag to mark a slot as filled. A pending hit is finished later without further action from the requester: once the awaited slot fills, the block reports a late hit for that line and removes it from the queue. Line data, cache writes and memory timing are handled outside this block.

Top module: `stream_prefetch_ctrl`

## Requirements
- R1: After reset no queue holds a stream, so no request, hit or late hit is reported, and the first lookup is a miss.
- R2: In a cycle with a lookup, exactly one of hit, pending hit or miss is asserted. With no lookup, none of them is asserted.
- R3: A newly taken queue requests the lines from miss address + 1 upward, one per request and in increasing order. It stops when DEPTH lines are outstanding or held, and it asks for the next line as soon as its oldest entry is removed.
- R4: While memBusy is high, reqValid stays low and no request is lost: the queued lines go out after memBusy falls.
- R5: A lookup that matches a filled oldest entry reports a hit with that queue's index and removes the entry. A fill that nobody is waiting on raises no late hit.
- R6: A lookup that matches an oldest entry not yet filled reports a pending hit. In the cycle after the fill for that entry is accepted, a late hit is reported with the line address and queue index, and the entry is then removed.
- R7: An address that matches only a non-oldest entry of a queue is a miss.
- R8: When several queues have free slots, their requests alternate in rotation, and no queue issues twice in a row while another is waiting.
- R9: On a miss, the queue that has gone longest without a hit, pending hit or allocation is taken. lookupBuf reports its index. After reset, queues rank from index 0 (most recent) to NUM_BUF-1 (least recent).
- R10: A fill whose tag belongs to a queue's previous stream, issued before that queue was taken over, is ignored. The new oldest entry stays unfilled and a lookup of it is a pending hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A cache miss is being looked up this cycle |
| missAddr | input | ADDR_W | Line address of the miss |
| lookupHit | output | 1 | Oldest entry matched and is filled; it is removed |
| lookupPend | output | 1 | Oldest entry matched but is not yet filled |
| lookupMiss | output | 1 | No oldest entry matched; a queue is taken over |
| lookupBuf | output | log2(NUM_BUF) | Queue that matched, or the one taken on a miss |
| memBusy | input | 1 | Memory bus busy; no request may issue |
| reqValid | output | 1 | A line request is issued and accepted this cycle |
| reqAddr | output | ADDR_W | Line address requested |
| reqTag | output | 1+log2(NUM_BUF)+log2(DEPTH) | Tag to return with the fill |
| respValid | input | 1 | A fill is returned this cycle |
| respTag | input | 1+log2(NUM_BUF)+log2(DEPTH) | Tag of the returned fill |
| lateHitValid | output | 1 | A deferred pending hit completes now |
| lateHitAddr | output | ADDR_W | Line address of the late hit |
| lateHitBuf | output | log2(NUM_BUF) | Queue of the late hit |

## Verification
A wrong oldest-entry pointer or line address in a queue shows up at the next lookup of that stream as a miss where a hit was expected. It also shows up within one cycle in the next refill address. A wrong slot count shows up as one request too many or too few, within a few idle cycles of a removal. Errors in the recency ranking are invisible until the next miss, which then names the wrong queue in lookupBuf. A fill wrongly accepted from a replaced stream turns the next pending hit into a hit in the same cycle as the lookup.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic pop;    // demand hit: remove oldest entry of popIdx
    logic pend;   // pending hit: mark popIdx as waiting
    logic alloc;  // miss: take over allocIdx
    logic issue;  // refill request from issueIdx
    logic late;   // deferred pop of lateIdx
  } sb_strobe_t;
endpackage

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 32,
  localparam int BUF_W  = $clog2(NUM_BUF),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int TAG_W  = 1 + BUF_W + SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  missAddr,
  input  sb_strobe_t         strobe,
  input  logic [BUF_W-1:0]   popIdx,
  input  logic [BUF_W-1:0]   allocIdx,
  input  logic [BUF_W-1:0]   issueIdx,
  input  logic [BUF_W-1:0]   lateIdx,
  input  logic               respValid,
  input  logic [TAG_W-1:0]   respTag,
  output logic [NUM_BUF-1:0] matchVec,
  output logic [NUM_BUF-1:0] headFilledVec,
  output logic [NUM_BUF-1:0] pendVec,
  output logic [NUM_BUF-1:0] canIssueVec,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [TAG_W-1:0]   reqTag,
  output logic [ADDR_W-1:0]  lateAddr
);

  logic [ADDR_W-1:0] headAddr [NUM_BUF];
  logic [SLOT_W-1:0] headPtr  [NUM_BUF];
  logic [CNT_W-1:0]  cnt      [NUM_BUF];
  logic [DEPTH-1:0]  filled   [NUM_BUF];
  logic [NUM_BUF-1:0] epoch, bufValid, pendPop;

  logic [SLOT_W-1:0] issueSlot [NUM_BUF];
  logic [NUM_BUF-1:0] popMask, pendMask, allocMask, issueMask, fillMask;

  logic              fEpoch;
  logic [BUF_W-1:0]  fBuf;
  logic [SLOT_W-1:0] fSlot;

  assign fEpoch = respTag[TAG_W-1];
  assign fBuf   = respTag[SLOT_W +: BUF_W];
  assign fSlot  = respTag[SLOT_W-1:0];

  always_comb begin
    for (int b = 0; b < NUM_BUF; b++) begin
      int s;
      s = int'(headPtr[b]) + int'(cnt[b]);
      if (s >= DEPTH) s = s - DEPTH;
      issueSlot[b]     = SLOT_W'(s);
      matchVec[b]      = bufValid[b] && (cnt[b] != '0) && (headAddr[b] == missAddr);
      headFilledVec[b] = filled[b][headPtr[b]];
      pendVec[b]       = pendPop[b];
      canIssueVec[b]   = bufValid[b] && (int'(cnt[b]) < DEPTH);
      popMask[b]   = (strobe.pop && popIdx == BUF_W'(b)) ||
                     (strobe.late && lateIdx == BUF_W'(b));
      pendMask[b]  = strobe.pend && popIdx == BUF_W'(b);
      allocMask[b] = strobe.alloc && allocIdx == BUF_W'(b);
      issueMask[b] = strobe.issue && issueIdx == BUF_W'(b);
      fillMask[b]  = respValid && bufValid[b] && fBuf == BUF_W'(b) && fEpoch == epoch[b];
    end
  end

  assign reqAddr  = headAddr[issueIdx] + ADDR_W'(cnt[issueIdx]);
  assign reqTag   = {epoch[issueIdx], issueIdx, issueSlot[issueIdx]};
  assign lateAddr = headAddr[lateIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BUF; b++) begin
        headAddr[b] <= '0;
        headPtr[b]  <= '0;
        cnt[b]      <= '0;
        filled[b]   <= '0;
      end
      epoch    <= '0;
      bufValid <= '0;
      pendPop  <= '0;
    end else begin
      for (int b = 0; b < NUM_BUF; b++) begin
        if (allocMask[b]) begin
          headAddr[b] <= missAddr + ADDR_W'(1);
          headPtr[b]  <= '0;
          cnt[b]      <= '0;
          filled[b]   <= '0;
          epoch[b]    <= ~epoch[b];
          bufValid[b] <= 1'b1;
          pendPop[b]  <= 1'b0;
        end else begin
          logic [DEPTH-1:0] f;
          f = filled[b];
          if (fillMask[b]) f[fSlot] = 1'b1;
          if (popMask[b])  f[headPtr[b]] = 1'b0;
          filled[b] <= f;
          if (popMask[b]) begin
            headPtr[b]  <= (int'(headPtr[b]) == DEPTH - 1) ? '0 : headPtr[b] + SLOT_W'(1);
            headAddr[b] <= headAddr[b] + ADDR_W'(1);
            pendPop[b]  <= 1'b0;
          end else if (pendMask[b]) begin
            pendPop[b]  <= 1'b1;
          end
          cnt[b] <= cnt[b] + CNT_W'(issueMask[b]) - CNT_W'(popMask[b]);
        end
      end
    end
  end

endmodule

// File: rtl/sbuf_control.sv
module sbuf_control
  import sbuf_pkg::*;
#(
  parameter int NUM_BUF = 4,
  localparam int BUF_W  = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               missValid,
  input  logic               memBusy,
  input  logic [NUM_BUF-1:0] matchVec,
  input  logic [NUM_BUF-1:0] headFilledVec,
  input  logic [NUM_BUF-1:0] pendVec,
  input  logic [NUM_BUF-1:0] canIssueVec,
  output sb_strobe_t         strobe,
  output logic [BUF_W-1:0]   popIdx,
  output logic [BUF_W-1:0]   allocIdx,
  output logic [BUF_W-1:0]   issueIdx,
  output logic [BUF_W-1:0]   lateIdx,
  output logic               lookupHit,
  output logic               lookupPend,
  output logic               lookupMiss,
  output logic [BUF_W-1:0]   lookupBuf,
  output logic               reqValid,
  output logic               lateHitValid
);

  logic [BUF_W-1:0] age [NUM_BUF];
  logic [BUF_W-1:0] rrPtr;
  logic             anyMatch, anyIssue, anyLate;
  logic [BUF_W-1:0] matchIdx, victim;
  logic [NUM_BUF-1:0] lateCand;

  always_comb begin
    anyMatch = 1'b0;
    matchIdx = '0;
    victim   = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        matchIdx = BUF_W'(i);
      end
      if (age[i] == BUF_W'(NUM_BUF - 1)) victim = BUF_W'(i);
    end
  end

  assign lookupHit  = missValid && anyMatch && headFilledVec[matchIdx];
  assign lookupPend = missValid && anyMatch && !headFilledVec[matchIdx];
  assign lookupMiss = missValid && !anyMatch;
  assign lookupBuf  = anyMatch ? matchIdx : victim;
  assign popIdx     = matchIdx;
  assign allocIdx   = victim;

  // deferred pops: skip a queue that a demand hit is already popping
  always_comb begin
    for (int i = 0; i < NUM_BUF; i++)
      lateCand[i] = pendVec[i] && headFilledVec[i] && !(lookupHit && matchIdx == BUF_W'(i));
    anyLate = 1'b0;
    lateIdx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (lateCand[i]) begin
        anyLate = 1'b1;
        lateIdx = BUF_W'(i);
      end
    end
  end
  assign lateHitValid = anyLate;

  // rotating refill arbiter, starting at rrPtr
  always_comb begin
    anyIssue = 1'b0;
    issueIdx = '0;
    for (int k = NUM_BUF - 1; k >= 0; k--) begin
      int c;
      c = int'(rrPtr) + k;
      if (c >= NUM_BUF) c = c - NUM_BUF;
      if (canIssueVec[c]) begin
        anyIssue = 1'b1;
        issueIdx = BUF_W'(c);
      end
    end
  end
  assign reqValid = !memBusy && anyIssue;

  always_comb begin
    strobe.pop   = lookupHit;
    strobe.pend  = lookupPend;
    strobe.alloc = lookupMiss;
    strobe.issue = reqValid;
    strobe.late  = anyLate;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BUF; i++) age[i] <= BUF_W'(i);
      rrPtr <= '0;
    end else begin
      if (missValid) begin
        for (int i = 0; i < NUM_BUF; i++) begin
          if (BUF_W'(i) == lookupBuf)          age[i] <= '0;
          else if (age[i] < age[lookupBuf])    age[i] <= age[i] + BUF_W'(1);
        end
      end
      if (reqValid)
        rrPtr <= (int'(issueIdx) == NUM_BUF - 1) ? '0 : issueIdx + BUF_W'(1);
    end
  end

endmodule

// File: rtl/stream_prefetch_ctrl.sv
module stream_prefetch_ctrl
  import sbuf_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 32,
  localparam int BUF_W  = $clog2(NUM_BUF),
  localparam int TAG_W  = 1 + BUF_W + $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              lookupHit,
  output logic              lookupPend,
  output logic              lookupMiss,
  output logic [BUF_W-1:0]  lookupBuf,
  input  logic              memBusy,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [TAG_W-1:0]  reqTag,
  input  logic              respValid,
  input  logic [TAG_W-1:0]  respTag,
  output logic              lateHitValid,
  output logic [ADDR_W-1:0] lateHitAddr,
  output logic [BUF_W-1:0]  lateHitBuf
);

  sb_strobe_t         strobe;
  logic [BUF_W-1:0]   popIdx, allocIdx, issueIdx, lateIdx;
  logic [NUM_BUF-1:0] matchVec, headFilledVec, pendVec, canIssueVec;

  sbuf_control #(.NUM_BUF(NUM_BUF)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .missValid(missValid), .memBusy(memBusy),
    .matchVec(matchVec), .headFilledVec(headFilledVec), .pendVec(pendVec),
    .canIssueVec(canIssueVec), .strobe(strobe), .popIdx(popIdx),
    .allocIdx(allocIdx), .issueIdx(issueIdx), .lateIdx(lateIdx),
    .lookupHit(lookupHit), .lookupPend(lookupPend), .lookupMiss(lookupMiss),
    .lookupBuf(lookupBuf), .reqValid(reqValid), .lateHitValid(lateHitValid)
  );

  sbuf_datapath #(.NUM_BUF(NUM_BUF), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .missAddr(missAddr), .strobe(strobe),
    .popIdx(popIdx), .allocIdx(allocIdx), .issueIdx(issueIdx), .lateIdx(lateIdx),
    .respValid(respValid), .respTag(respTag), .matchVec(matchVec),
    .headFilledVec(headFilledVec), .pendVec(pendVec), .canIssueVec(canIssueVec),
    .reqAddr(reqAddr), .reqTag(reqTag), .lateAddr(lateHitAddr)
  );

  assign lateHitBuf = lateIdx;

endmodule

// File: rtl/stream_prefetch_ctrl_chk.sv
module stream_prefetch_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int BUF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              missValid,
  input logic              memBusy,
  input logic              lookupHit,
  input logic              lookupPend,
  input logic              lookupMiss,
  input logic [BUF_W-1:0]  lookupBuf,
  input logic              reqValid,
  input logic              lateHitValid,
  input logic [ADDR_W-1:0] lateHitAddr,
  input logic [BUF_W-1:0]  lateHitBuf
);

  // R4
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memBusy |-> !reqValid);

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    missValid |-> $onehot({lookupHit, lookupPend, lookupMiss}));

  // R2
  no_lookup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !missValid |-> !(lookupHit || lookupPend || lookupMiss));

  // R6
  late_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lateHitValid |=> !lateHitValid || lateHitBuf != $past(lateHitBuf) ||
                     lateHitAddr != $past(lateHitAddr));

  // R5
  no_double_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupHit && lateHitValid) |-> lateHitBuf != lookupBuf);

endmodule

bind stream_prefetch_ctrl stream_prefetch_ctrl_chk #(.ADDR_W(ADDR_W), .BUF_W(BUF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .missValid(missValid), .memBusy(memBusy),
  .lookupHit(lookupHit), .lookupPend(lookupPend), .lookupMiss(lookupMiss),
  .lookupBuf(lookupBuf), .reqValid(reqValid), .lateHitValid(lateHitValid),
  .lateHitAddr(lateHitAddr), .lateHitBuf(lateHitBuf)
);

// File: tb/stream_prefetch_ctrl_tb_top.sv
module stream_prefetch_ctrl_tb_top;
  localparam int NB = 4, DP = 4, AW = 32, BW = 2, TW = 5;

  logic clk = 0, rst_n = 0, missValid = 0, memBusy = 0, respValid = 0;
  logic [AW-1:0] missAddr = '0;
  logic [TW-1:0] respTag = '0;
  logic lookupHit, lookupPend, lookupMiss, reqValid, lateHitValid;
  logic [BW-1:0] lookupBuf, lateHitBuf;
  logic [AW-1:0] reqAddr, lateHitAddr;
  logic [TW-1:0] reqTag;

  int nTests = 0, nFail = 0;
  logic [AW-1:0] logAddr [64];
  logic [TW-1:0] logTag  [64];
  int logN = 0, base = 0;
  logic [TW-1:0] savedTag [4];
  logic [TW-1:0] staleTag;
  logic h, p, m;
  logic [BW-1:0] b;

  always #5 clk = ~clk;

  stream_prefetch_ctrl #(.NUM_BUF(NB), .DEPTH(DP), .ADDR_W(AW)) dut_i (.*);

  // request log, sampled mid-low-phase before the accepting edge
  always @(negedge clk) begin
    #3;
    if (reqValid && logN < 64) begin
      logAddr[logN] = reqAddr;
      logTag[logN]  = reqTag;
      logN = logN + 1;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a);
    @(negedge clk);
    missValid = 1; missAddr = a;
    #2;
    h = lookupHit; p = lookupPend; m = lookupMiss; b = lookupBuf;
    @(posedge clk); #1 missValid = 0;
  endtask

  task automatic respond(input logic [TW-1:0] t);
    @(negedge clk);
    respValid = 1; respTag = t;
    @(posedge clk); #1 respValid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    idle(3); rst_n = 1; #2;
    check(reqValid == 0, "R1 reqValid", 32'(reqValid), 0);
    check(lateHitValid == 0, "R1 lateHit", 32'(lateHitValid), 0);
  endtask

  task automatic t_first_miss;
    @(negedge clk); memBusy = 1;
    lookup(32'h100);
    check(m && !h && !p, "R1 first lookup miss", {29'd0, h, p, m}, 1);
    check(b == 2'd3, "R9 first victim", 32'(b), 3);
    base = logN;
    idle(3); #2;
    check(reqValid == 0, "R4 busy holds req", 32'(reqValid), 0);
    check(logN == base, "R4 no req while busy", logN - base, 0);
  endtask

  task automatic t_refill;
    base = logN;
    @(negedge clk); memBusy = 0;
    idle(8);
    check(logN - base == 4, "R3 stops at depth", logN - base, 4);
    for (int i = 0; i < 4; i++) begin
      check(logAddr[base+i] == 32'h101 + i, "R3 sequential addr", logAddr[base+i], 32'h101 + i);
      savedTag[i] = logTag[base+i];
    end
  endtask

  task automatic t_pending;
    base = logN;
    lookup(32'h101);
    check(p && !h && !m && b == 2'd3, "R6 pending hit", {27'd0, b, h, p, m}, {27'd0, 2'd3, 3'b010});
    respond(savedTag[0]);
    #1;
    check(lateHitValid == 1, "R6 late hit", 32'(lateHitValid), 1);
    check(lateHitAddr == 32'h101, "R6 late addr", lateHitAddr, 32'h101);
    check(lateHitBuf == 2'd3, "R6 late buf", 32'(lateHitBuf), 3);
    idle(4);
    check(logN - base == 1 && logAddr[base] == 32'h105, "R3 refill after pop", logAddr[base], 32'h105);
  endtask

  task automatic t_hit;
    base = logN;
    respond(savedTag[1]);
    #1;
    check(lateHitValid == 0, "R5 unwaited fill silent", 32'(lateHitValid), 0);
    lookup(32'h102);
    check(h && !p && !m && b == 2'd3, "R5 demand hit", {27'd0, b, h, p, m}, {27'd0, 2'd3, 3'b100});
    idle(4);
    check(logN - base == 1 && logAddr[base] == 32'h106, "R5 pop frees slot", logAddr[base], 32'h106);
  endtask

  task automatic t_non_head;
    base = logN;
    lookup(32'h104);
    check(m && !h && !p, "R7 non-head miss", {29'd0, h, p, m}, 1);
    check(b == 2'd2, "R9 lru victim", 32'(b), 2);
    idle(6);
    check(logN - base == 4 && logAddr[base] == 32'h105, "R3 new stream start", logAddr[base], 32'h105);
    staleTag = logTag[base];
  endtask

  task automatic t_rotation;
    bit ok;
    int nextA, nextB;
    @(negedge clk); memBusy = 1;
    lookup(32'h500);
    check(m && b == 2'd1, "R9 victim second", 32'(b), 1);
    lookup(32'h900);
    check(m && b == 2'd0, "R9 victim third", 32'(b), 0);
    base = logN;
    @(negedge clk); memBusy = 0;
    idle(10);
    check(logN - base == 8, "R8 request count", logN - base, 8);
    ok = 1; nextA = 32'h501; nextB = 32'h901;
    for (int i = 0; i < 8; i++) begin
      if (logAddr[base+i][11:8] == 4'h5) begin
        if (logAddr[base+i] != 32'(nextA)) ok = 0;
        nextA++;
      end else begin
        if (logAddr[base+i] != 32'(nextB)) ok = 0;
        nextB++;
      end
      if (i > 0 && logAddr[base+i][11:8] == logAddr[base+i-1][11:8]) ok = 0;
    end
    check(ok, "R8 alternating streams", logAddr[base+1], 32'h501);
  endtask

  task automatic t_lru_and_stale;
    @(negedge clk); memBusy = 1;
    lookup(32'h103);
    check(p && b == 2'd3, "R6 pending on unfilled", {29'd0, h, p, m}, 2);
    lookup(32'hA00);
    check(m && b == 2'd2, "R9 touch makes recent", 32'(b), 2);
    base = logN;
    @(negedge clk); memBusy = 0;
    idle(6);
    check(logN - base == 4 && logAddr[base] == 32'hA01, "R4 release after busy", logAddr[base], 32'hA01);
    respond(staleTag);
    lookup(32'hA01);
    check(p && !h && b == 2'd2, "R10 stale fill ignored", {29'd0, h, p, m}, 2);
  endtask

  initial begin
    #(200000 * 10);
    nFail++; nTests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_first_miss();
    t_refill();
    t_pending();
    t_hit();
    t_non_head();
    t_rotation();
    t_lru_and_stale();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule